// File: doc/BRIEF.md
# CPU Clock Stop and Power-Down Sequencer

This block decides, cycle by cycle, how the differential CPU clock pairs and the single-ended clock groups of a clock generator behave when the system asks them to stop or to power down. It runs on the CPU clock. It takes two asynchronous active-low request pins, one for CPU-stop and one for power-down, and a small set of configuration bits. For each CPU pair it produces a 2-bit drive code that the analog output stage decodes. For each single-ended group it produces a hold-low enable.

A power-down request acts only after it has been seen on two consecutive synchronized samples. While powered down, every CPU pair parks and every group is forced low. A CPU-stop request parks the pairs that are not marked free-running. It can also hold the two 66 MHz-class groups, each only if that group's own enable bit is set. When a request is withdrawn, the block passes through a fixed two-cycle resume phase. During that phase the halted pairs have their true leg driven high before they toggle again. The current sequencing state is exported for observation.

Top module: `cstop_seq`

## Requirements
- R1: `state_o` encodes the sequencing state as RUN=0, STOP_PENDING=1, STOPPED=2, PD_PENDING=3, PD=4, RESUME=5. After reset the state is RUN, every pair code is 0 and no group hold is set.
- R2: Both request pins pass through a two-flop synchronizer. A pin change driven in cycle N first affects `state_o` in cycle N+3. Power-down moves RUN to PD_PENDING on the first low sample and reaches PD only if the next sample is also low. A single-sample low pulse returns to RUN.
- R3: Pair drive codes are 0 = toggling, 1 = true high and complement low, 2 = true high at double reference current with complement undriven, 3 = both legs undriven. In PD every pair, free-running or not, shows code 2 when `cfg_pd_float` is 0 and code 3 when it is 1.
- R4: A CPU-stop request spends exactly one cycle in STOP_PENDING and then reaches STOPPED. There, each stoppable pair shows code 1 when `cfg_stop_float` is 0 and code 3 when it is 1.
- R5: A pair whose bit in `cfg_pair_freerun` is 1 keeps code 0 throughout a CPU-stop. A bit of 0 (the reset value of a cleared register) makes that pair stoppable.
- R6: When the last request is withdrawn, the block stays in RESUME for exactly two cycles and then returns to RUN. During RESUME every pair that was halted shows code 1, so a floated true leg is driven high before toggling resumes.
- R7: A group hold engages only in a cycle after its `grp_lvl` bit was sampled low, so it engages on the group's falling transition. A group still high keeps running until it goes low. A hold is released only after its level was sampled low.
- R8: During STOPPED, group bit 0 (the three-output 66 MHz group) is held only if `cfg_grp_stop_en` is 1. Group bit 1 (the shared 66 MHz output) is held only if `cfg_single_stop_en` is 1. Groups 2 and up are never held by CPU-stop.
- R9: If both requests arrive in the same cycle, power-down wins and the state goes to PD_PENDING. If power-down is withdrawn while CPU-stop is still asserted, PD exits directly to STOPPED.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_stop_n | input | 1 | Asynchronous active-low CPU-stop request |
| pd_n | input | 1 | Asynchronous active-low power-down request |
| cfg_stop_float | input | 1 | 0: stopped pairs park high/low; 1: stopped pairs float |
| cfg_pd_float | input | 1 | 0: power-down parks true high at double current; 1: both legs float |
| cfg_pair_freerun | input | NPAIR | Per-pair exemption from CPU-stop |
| cfg_grp_stop_en | input | 1 | Lets CPU-stop hold group 0 |
| cfg_single_stop_en | input | 1 | Lets CPU-stop hold group 1 |
| grp_lvl | input | NGRP | Present level of each single-ended group clock |
| pair_mode | output | 2*NPAIR | Drive code per pair, pair p at bits [2p+1:2p] |
| grp_hold_lo | output | NGRP | Hold-low enable per group |
| state_o | output | 3 | Sequencing state |

## Verification
CPU-stop and power-down can act in the same cycle. The bench drives both pins low on the same clock and expects PD_PENDING, then PD with float codes, which shows that power-down has priority. It then withdraws only power-down and expects the state to go straight to STOPPED. In that state the free-running pair toggles, the other pair parks, and the power-down group holds let go once their levels allow it. Group holds that engage during power-down while a group's level is still high are also checked, to show that the hold waits for the falling transition.

// File: rtl/cstop_pkg.sv
package cstop_pkg;

    typedef enum logic [2:0] {
        ST_RUN       = 3'd0,
        ST_STOP_PEND = 3'd1,
        ST_STOPPED   = 3'd2,
        ST_PD_PEND   = 3'd3,
        ST_PD        = 3'd4,
        ST_RESUME    = 3'd5
    } seq_state_e;

    typedef enum logic [1:0] {
        PM_RUN     = 2'd0,
        PM_PARK    = 2'd1,
        PM_PARK_X2 = 2'd2,
        PM_FLOAT   = 2'd3
    } pair_mode_e;

endpackage

// File: rtl/cstop_sync.sv
module cstop_sync #(
    parameter int   WIDTH  = 2,
    parameter int   STAGES = 2,
    parameter logic IDLE   = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_i[b]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{IDLE}};
            else        chain_q <= chain_d;
        end

        assign sync_o[b] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/cstop_fsm.sv
module cstop_fsm
    import cstop_pkg::*;
#(
    parameter int RESUME_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pd_act,
    input  logic       stop_act,
    output seq_state_e st_o,
    output logic       eff_stop_o
);

    localparam int CW = (RESUME_CYC > 1) ? $clog2(RESUME_CYC) : 1;
    localparam logic [CW-1:0] CNT_LOAD = CW'(RESUME_CYC - 1);

    typedef struct packed {
        seq_state_e    st;
        logic          was_stop;
        logic [CW-1:0] cnt;
    } fsm_t;

    fsm_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_RUN: begin
                if (pd_act) begin
                    r_d.st       = ST_PD_PEND;
                    r_d.was_stop = 1'b0;
                end else if (stop_act) begin
                    r_d.st = ST_STOP_PEND;
                end
            end
            ST_STOP_PEND: begin
                if (pd_act) begin
                    r_d.st       = ST_PD_PEND;
                    r_d.was_stop = 1'b0;
                end else if (!stop_act) begin
                    r_d.st = ST_RUN;
                end else begin
                    r_d.st = ST_STOPPED;
                end
            end
            ST_STOPPED: begin
                if (pd_act) begin
                    r_d.st       = ST_PD_PEND;
                    r_d.was_stop = 1'b1;
                end else if (!stop_act) begin
                    r_d.st  = ST_RESUME;
                    r_d.cnt = CNT_LOAD;
                end
            end
            ST_PD_PEND: begin
                if (pd_act) begin
                    r_d.st = ST_PD;
                end else if (r_q.was_stop) begin
                    if (stop_act) begin
                        r_d.st = ST_STOPPED;
                    end else begin
                        r_d.st  = ST_RESUME;
                        r_d.cnt = CNT_LOAD;
                    end
                end else if (stop_act) begin
                    r_d.st = ST_STOP_PEND;
                end else begin
                    r_d.st = ST_RUN;
                end
            end
            ST_PD: begin
                if (!pd_act) begin
                    if (stop_act) begin
                        r_d.st = ST_STOPPED;
                    end else begin
                        r_d.st  = ST_RESUME;
                        r_d.cnt = CNT_LOAD;
                    end
                end
            end
            ST_RESUME: begin
                if (pd_act) begin
                    r_d.st       = ST_PD_PEND;
                    r_d.was_stop = 1'b0;
                end else if (stop_act) begin
                    r_d.st = ST_STOP_PEND;
                end else if (r_q.cnt == '0) begin
                    r_d.st = ST_RUN;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            default: r_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_RUN, was_stop: 1'b0, cnt: '0};
        else        r_q <= r_d;
    end

    assign st_o       = r_q.st;
    assign eff_stop_o = (r_q.st == ST_STOPPED) || ((r_q.st == ST_PD_PEND) && r_q.was_stop);

endmodule

// File: rtl/cstop_pair.sv
module cstop_pair
    import cstop_pkg::*;
#(
    parameter int NPAIR = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  seq_state_e         st,
    input  logic               eff_stop,
    input  logic [NPAIR-1:0]   freerun,
    input  logic               stop_float,
    input  logic               pd_float,
    output logic [2*NPAIR-1:0] mode_o
);

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        logic       held_d, held_q;
        pair_mode_e mode;

        always_comb begin
            if (st == ST_PD)                                  held_d = 1'b1;
            else if (eff_stop)                                held_d = ~freerun[p];
            else if (st == ST_RESUME || st == ST_PD_PEND)     held_d = held_q;
            else                                              held_d = 1'b0;

            if (st == ST_PD)
                mode = pd_float ? PM_FLOAT : PM_PARK_X2;
            else if (eff_stop)
                mode = freerun[p] ? PM_RUN : (stop_float ? PM_FLOAT : PM_PARK);
            else if ((st == ST_RESUME || st == ST_PD_PEND) && held_q)
                mode = PM_PARK;
            else
                mode = PM_RUN;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) held_q <= 1'b0;
            else        held_q <= held_d;
        end

        assign mode_o[2*p +: 2] = mode;
    end

endmodule

// File: rtl/cstop_hold.sv
module cstop_hold #(
    parameter int NGRP = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NGRP-1:0] want,
    input  logic [NGRP-1:0] lvl,
    output logic [NGRP-1:0] hold_o
);

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        logic hold_d, hold_q;

        always_comb begin
            if (want[g]) hold_d = hold_q | ~lvl[g];
            else         hold_d = hold_q & lvl[g];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hold_q <= 1'b0;
            else        hold_q <= hold_d;
        end

        assign hold_o[g] = hold_q;
    end

endmodule

// File: rtl/cstop_seq.sv
module cstop_seq
    import cstop_pkg::*;
#(
    parameter int NPAIR       = 2,
    parameter int NGRP        = 5,
    parameter int SYNC_STAGES = 2,
    parameter int RESUME_CYC  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_stop_n,
    input  logic               pd_n,
    input  logic               cfg_stop_float,
    input  logic               cfg_pd_float,
    input  logic [NPAIR-1:0]   cfg_pair_freerun,
    input  logic               cfg_grp_stop_en,
    input  logic               cfg_single_stop_en,
    input  logic [NGRP-1:0]    grp_lvl,
    output logic [2*NPAIR-1:0] pair_mode,
    output logic [NGRP-1:0]    grp_hold_lo,
    output logic [2:0]         state_o
);

    localparam int REQ_W = 2;

    logic [REQ_W-1:0] req_s;
    seq_state_e       st;
    logic             eff_stop;
    logic [NGRP-1:0]  want;

    cstop_sync #(.WIDTH(REQ_W), .STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({pd_n, cpu_stop_n}),
        .sync_o  (req_s)
    );

    cstop_fsm #(.RESUME_CYC(RESUME_CYC)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pd_act     (~req_s[1]),
        .stop_act   (~req_s[0]),
        .st_o       (st),
        .eff_stop_o (eff_stop)
    );

    cstop_pair #(.NPAIR(NPAIR)) u_pair (
        .clk        (clk),
        .rst_n      (rst_n),
        .st         (st),
        .eff_stop   (eff_stop),
        .freerun    (cfg_pair_freerun),
        .stop_float (cfg_stop_float),
        .pd_float   (cfg_pd_float),
        .mode_o     (pair_mode)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_want
        if (g == 0) begin : g_trio
            assign want[g] = (st == ST_PD) || (eff_stop && cfg_grp_stop_en);
        end else if (g == 1) begin : g_single
            assign want[g] = (st == ST_PD) || (eff_stop && cfg_single_stop_en);
        end else begin : g_other
            assign want[g] = (st == ST_PD);
        end
    end

    cstop_hold #(.NGRP(NGRP)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .want   (want),
        .lvl    (grp_lvl),
        .hold_o (grp_hold_lo)
    );

    assign state_o = st;

endmodule

// File: rtl/cstop_seq_chk.sv
module cstop_seq_chk #(
    parameter int NPAIR = 2,
    parameter int NGRP  = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic [2:0]         state_o,
    input logic [2*NPAIR-1:0] pair_mode,
    input logic [NGRP-1:0]    grp_hold_lo,
    input logic [NGRP-1:0]    grp_lvl,
    input logic               cfg_pd_float,
    input logic [NPAIR-1:0]   cfg_pair_freerun
);

    p_pd_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd4) |-> ($past(state_o) == 3'd3 || $past(state_o) == 3'd4));

    p_stop_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd2) |-> ($past(state_o) inside {3'd1, 3'd2, 3'd3, 3'd4}));

    for (genvar p = 0; p < NPAIR; p++) begin : g_pchk
        p_pd_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (state_o == 3'd4) |-> (pair_mode[2*p +: 2] == (cfg_pd_float ? 2'd3 : 2'd2)));

        p_freerun_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (state_o == 3'd2 && cfg_pair_freerun[p]) |-> (pair_mode[2*p +: 2] == 2'd0));

        p_resume_driven_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (state_o == 3'd5) |-> (pair_mode[2*p +: 2] inside {2'd0, 2'd1}));
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_gchk
        p_hold_on_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(grp_hold_lo[g]) |-> !$past(grp_lvl[g]));

        p_release_on_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(grp_hold_lo[g]) |-> !$past(grp_lvl[g]));
    end

endmodule

bind cstop_seq cstop_seq_chk #(.NPAIR(NPAIR), .NGRP(NGRP)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .state_o          (state_o),
    .pair_mode        (pair_mode),
    .grp_hold_lo      (grp_hold_lo),
    .grp_lvl          (grp_lvl),
    .cfg_pd_float     (cfg_pd_float),
    .cfg_pair_freerun (cfg_pair_freerun)
);

// File: tb/cstop_seq_tb_top.sv
`timescale 1ns/1ps
module cstop_seq_tb_top;

    localparam int NPAIR = 2;
    localparam int NGRP  = 5;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic               rst_n = 1'b0;
    logic               cpu_stop_n = 1'b1;
    logic               pd_n = 1'b1;
    logic               cfg_stop_float = 1'b0;
    logic               cfg_pd_float = 1'b0;
    logic [NPAIR-1:0]   cfg_pair_freerun = '0;
    logic               cfg_grp_stop_en = 1'b0;
    logic               cfg_single_stop_en = 1'b0;
    logic [NGRP-1:0]    grp_lvl = '0;
    logic [2*NPAIR-1:0] pair_mode;
    logic [NGRP-1:0]    grp_hold_lo;
    logic [2:0]         state_o;

    cstop_seq #(.NPAIR(NPAIR), .NGRP(NGRP)) dut_i (
        .clk                (clk),
        .rst_n              (rst_n),
        .cpu_stop_n         (cpu_stop_n),
        .pd_n               (pd_n),
        .cfg_stop_float     (cfg_stop_float),
        .cfg_pd_float       (cfg_pd_float),
        .cfg_pair_freerun   (cfg_pair_freerun),
        .cfg_grp_stop_en    (cfg_grp_stop_en),
        .cfg_single_stop_en (cfg_single_stop_en),
        .grp_lvl            (grp_lvl),
        .pair_mode          (pair_mode),
        .grp_hold_lo        (grp_hold_lo),
        .state_o            (state_o)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int         at;
        logic [2:0] st;
        logic [3:0] pm;
        logic [4:0] hold;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    task automatic expect_at(int k, logic [2:0] st, logic [3:0] pm, logic [4:0] hold, string tag);
        exp_t e;
        e.at = cyc + k; e.st = st; e.pm = pm; e.hold = hold; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    always @(negedge clk) begin
        exp_t e;
        while (q.size() > 0 && q[0].at < cyc) begin
            e = q.pop_front();
            n_chk++; n_bad++;
            $display("FAIL %s: cycle %0d not compared, actual none expected st=%0d", e.tag, e.at, e.st);
        end
        while (q.size() > 0 && q[0].at == cyc) begin
            e = q.pop_front();
            n_chk++;
            if (state_o !== e.st || pair_mode !== e.pm || grp_hold_lo !== e.hold) begin
                n_bad++;
                $display("FAIL %s @%0d: actual st=%0d pm=%b hold=%b expected st=%0d pm=%b hold=%b",
                         e.tag, cyc, state_o, pair_mode, grp_hold_lo, e.st, e.pm, e.hold);
            end
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        expect_at(1, 3'd0, 4'b0000, 5'b00000, "R1 reset state");
        step(4);

        // R2: one-sample power-down pulse
        pd_n = 1'b0;
        expect_at(2, 3'd0, 4'b0000, 5'b00000, "R2 still synchronizing");
        expect_at(3, 3'd3, 4'b0000, 5'b00000, "R2 first sample");
        expect_at(4, 3'd0, 4'b0000, 5'b00000, "R2 single sample rejected");
        step(1);
        pd_n = 1'b1;
        step(8);

        // R3 / R7: power-down, park at double current, REF-like group high
        grp_lvl = 5'b10000;
        cfg_pd_float = 1'b0;
        pd_n = 1'b0;
        expect_at(3, 3'd3, 4'b0000, 5'b00000, "R2 pending");
        expect_at(4, 3'd4, 4'b1010, 5'b00000, "R3 park x2");
        expect_at(5, 3'd4, 4'b1010, 5'b01111, "R7 low groups held");
        expect_at(6, 3'd4, 4'b1010, 5'b01111, "R7 high group waits");
        step(6);
        grp_lvl = 5'b00000;
        expect_at(1, 3'd4, 4'b1010, 5'b11111, "R7 group held after fall");
        step(3);
        grp_lvl = 5'b10000;
        pd_n = 1'b1;
        expect_at(2, 3'd4, 4'b1010, 5'b11111, "R6 still down");
        expect_at(3, 3'd5, 4'b0101, 5'b11111, "R6 resume true high");
        expect_at(4, 3'd5, 4'b0101, 5'b10000, "R7 release only when low");
        expect_at(5, 3'd0, 4'b0000, 5'b10000, "R6 back to run");
        step(5);
        grp_lvl = 5'b00000;
        expect_at(1, 3'd0, 4'b0000, 5'b00000, "R7 released on low");
        step(4);

        // R4 / R5 / R8: stop, pair1 free-running, trio group enabled
        cfg_pair_freerun = 2'b10;
        cfg_stop_float = 1'b0;
        cfg_grp_stop_en = 1'b1;
        cfg_single_stop_en = 1'b0;
        cpu_stop_n = 1'b0;
        expect_at(3, 3'd1, 4'b0000, 5'b00000, "R4 stop pending");
        expect_at(4, 3'd2, 4'b0001, 5'b00000, "R4 park R5 freerun");
        expect_at(5, 3'd2, 4'b0001, 5'b00001, "R8 trio group held");
        expect_at(8, 3'd2, 4'b0001, 5'b00001, "R8 other groups run");
        step(9);
        cpu_stop_n = 1'b1;
        expect_at(3, 3'd5, 4'b0001, 5'b00001, "R6 resume");
        expect_at(4, 3'd5, 4'b0001, 5'b00000, "R6 resume second cycle");
        expect_at(5, 3'd0, 4'b0000, 5'b00000, "R6 run");
        step(7);

        // R4 float / R8 single group
        cfg_pair_freerun = 2'b00;
        cfg_stop_float = 1'b1;
        cfg_grp_stop_en = 1'b0;
        cfg_single_stop_en = 1'b1;
        cpu_stop_n = 1'b0;
        expect_at(4, 3'd2, 4'b1111, 5'b00000, "R4 float");
        expect_at(5, 3'd2, 4'b1111, 5'b00010, "R8 single group held");
        step(7);
        cpu_stop_n = 1'b1;
        expect_at(3, 3'd5, 4'b0101, 5'b00010, "R6 float to high");
        expect_at(4, 3'd5, 4'b0101, 5'b00000, "R6 still high");
        expect_at(5, 3'd0, 4'b0000, 5'b00000, "R6 run");
        step(7);

        // R9: both requests same cycle
        cfg_pair_freerun = 2'b01;
        cfg_stop_float = 1'b0;
        cfg_pd_float = 1'b1;
        cfg_grp_stop_en = 1'b0;
        cfg_single_stop_en = 1'b0;
        pd_n = 1'b0;
        cpu_stop_n = 1'b0;
        expect_at(3, 3'd3, 4'b0000, 5'b00000, "R9 power-down wins");
        expect_at(4, 3'd4, 4'b1111, 5'b00000, "R3 float all pairs");
        expect_at(5, 3'd4, 4'b1111, 5'b11111, "R7 all held");
        step(7);
        pd_n = 1'b1;
        expect_at(3, 3'd2, 4'b0100, 5'b11111, "R9 exit to stopped");
        expect_at(4, 3'd2, 4'b0100, 5'b00000, "R8 groups not held by stop");
        step(6);
        cpu_stop_n = 1'b1;
        expect_at(3, 3'd5, 4'b0100, 5'b00000, "R6 resume halted pair");
        expect_at(5, 3'd0, 4'b0000, 5'b00000, "R6 run");
        step(7);

        wait (q.size() == 0);
        step(2);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule